// File: doc/BRIEF.md
# Vblank Evasion Update Guard

This block decides when a display pipe may begin a multi-register update so that the whole update lands inside one frame. A requester raises `req`. The block then samples the mode timing: pixel clock in kHz, horizontal total, the line where vertical blank starts, and the interlace flag. From these it derives a guard band of scanlines that lies just ahead of vertical blank. The guard is sized to cover a fixed time budget, 100 µs by default. While the live scanline sits inside that band, the grant is held back. The grant is released once the scanline is outside the band or a cycle-count timeout expires.

At grant time the block copies the pipe's frame counter. It keeps the grant high until the requester signals `done`. At that point it compares the copied count with the live frame counter. A mismatch means a vertical blank slipped into the middle of the update. There are two sticky flags, and both stay set until the next accepted request clears them:

- `evade_fail` reports that the grant was forced by the timeout.
- `update_fail` reports that an update crossed a vertical blank.

Top module: `vbl_guard`

## Requirements
- R1: The guard length in lines is ceil(BUDGET_US × pix_khz / (1000 × htotal)), and the band covers lines vbl_start − guard through vbl_start − 1, both ends included.
- R2: When htotal is 0, the guard length is 1 line.
- R3: With interlace set to 1, the effective vblank start is (vbl_start + 1) / 2, rounded down, before the band is derived.
- R4: A request is captured only while the block is idle, meaning neither granted nor waiting. If the scanline lies outside the band, grant rises one cycle after the capture edge and evade_fail stays 0.
- R5: If the band's lower end is ≤ 0 or its upper end is ≤ 0, grant rises one cycle after capture whatever the scanline is, and start_count is 0. With start_count 0, no crossing check is made at done.
- R6: If the scanline stays inside the band, grant rises exactly TIMEOUT_CYC cycles after the capture edge and evade_fail goes to 1.
- R7: When grant rises, start_count takes the value of frame_cnt. Grant then stays at 1 and start_count stays unchanged until done is sampled at 1.
- R8: When done is sampled during grant, grant falls on the next edge. At the same edge update_fail becomes 1 if start_count is nonzero and differs from frame_cnt, and 0 otherwise.
- R9: A captured request clears evade_fail and update_fail on its capture edge.
- R10: The band is computed only from the timing inputs present at the capture edge. Changes to pix_khz, htotal, vbl_start or interlace during the wait have no effect.
- R11: If the scanline leaves the band during the wait, grant rises on the first edge at which the block sees it outside.
- R12: After reset, grant, evade_fail, update_fail and start_count are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_khz | input | PCLK_W | Pixel clock in kHz |
| htotal | input | HT_W | Horizontal total in pixels |
| vbl_start | input | LN_W | First line of vertical blank |
| interlace | input | 1 | 1 = interlaced mode |
| scanline | input | LN_W | Current scanline of the pipe |
| frame_cnt | input | FC_W | Pipe frame (vblank) counter |
| req | input | 1 | Request to start an update |
| done | input | 1 | Update finished |
| grant | output | 1 | Update may proceed; held until done |
| start_count | output | FC_W | Frame count copied at grant |
| evade_fail | output | 1 | Sticky: grant forced by timeout |
| update_fail | output | 1 | Sticky: update crossed a vblank |

## Verification
The assertions check the following properties on every cycle:

- The grant holds until done and falls right after it.
- The start count stays fixed while granted.
- A timeout flag only appears together with a grant.
- The crossing flag only appears after a done.
- A captured request clears both flags.
- Waiting never runs past the timeout count.

Only the bench scenarios can show the arithmetic behind the guard band. This covers the ceiling rounding, the zero-htotal case, interlace halving and the bypass at the band's lower ends. The scenarios also show the effect of a scanline moving mid-wait, and that timing inputs changed during a wait are ignored.

// File: rtl/vbl_guard_pkg.sv
package vbl_guard_pkg;

    localparam int WIN_W = 32;

    typedef logic signed [WIN_W-1:0] line_t;

    typedef struct packed {
        logic  bypass;
        line_t lo;
        line_t hi;
    } window_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_HELD = 2'd2
    } phase_e;

    function automatic logic line_outside(input line_t l, input window_t w);
        return (l < w.lo) || (l > w.hi);
    endfunction

endpackage

// File: rtl/vbl_window.sv
module vbl_window
    import vbl_guard_pkg::*;
#(
    parameter int PCLK_W    = 20,
    parameter int HT_W      = 14,
    parameter int LN_W      = 14,
    parameter int BUDGET_US = 100
) (
    input  logic [PCLK_W-1:0] pix_khz,
    input  logic [HT_W-1:0]   htotal,
    input  logic [LN_W-1:0]   vbl_start,
    input  logic              interlace,
    output window_t           win
);
    localparam int NUM_W = PCLK_W + $clog2(BUDGET_US + 1);
    localparam int DEN_W = HT_W + 10;
    localparam int DW    = ((NUM_W > DEN_W) ? NUM_W : DEN_W) + 1;

    logic [DW-1:0]   num, den, guard;
    logic [LN_W:0]   vs_eff;
    line_t           lo, hi;

    always_comb begin
        num = DW'(pix_khz) * DW'(BUDGET_US);
        den = (htotal == '0) ? DW'(1) : DW'(htotal) * DW'(1000);
        guard = (htotal == '0) ? DW'(1) : (num + den - DW'(1)) / den;
        vs_eff = interlace ? (({1'b0, vbl_start} + (LN_W+1)'(1)) >> 1)
                           : {1'b0, vbl_start};
        lo = $signed(WIN_W'(vs_eff)) - $signed(WIN_W'(guard));
        hi = $signed(WIN_W'(vs_eff)) - line_t'(1);
        win.lo = lo;
        win.hi = hi;
        win.bypass = (lo <= 0) || (hi <= 0);
    end
endmodule

// File: rtl/vbl_timer.sv
module vbl_timer #(
    parameter int LIMIT = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + CW'(1);
    end

    assign expire = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/vbl_guard.sv
module vbl_guard
    import vbl_guard_pkg::*;
#(
    parameter int PCLK_W      = 20,
    parameter int HT_W        = 14,
    parameter int LN_W        = 14,
    parameter int FC_W        = 32,
    parameter int BUDGET_US   = 100,
    parameter int TIMEOUT_CYC = 250000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PCLK_W-1:0] pix_khz,
    input  logic [HT_W-1:0]   htotal,
    input  logic [LN_W-1:0]   vbl_start,
    input  logic              interlace,
    input  logic [LN_W-1:0]   scanline,
    input  logic [FC_W-1:0]   frame_cnt,
    input  logic              req,
    input  logic              done,
    output logic              grant,
    output logic [FC_W-1:0]   start_count,
    output logic              evade_fail,
    output logic              update_fail
);
    phase_e        phase;
    window_t       win_d, win_q;
    logic [FC_W-1:0] start_q;
    logic          evade_q, upd_q, expire, in_wait, outside;

    vbl_window #(
        .PCLK_W(PCLK_W), .HT_W(HT_W), .LN_W(LN_W), .BUDGET_US(BUDGET_US)
    ) u_win (
        .pix_khz(pix_khz), .htotal(htotal), .vbl_start(vbl_start),
        .interlace(interlace), .win(win_d)
    );

    assign in_wait = (phase == PH_WAIT);

    vbl_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
        .clk(clk), .rst(rst), .run(in_wait), .expire(expire)
    );

    assign outside = line_outside($signed(WIN_W'(scanline)), win_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            win_q   <= '0;
            start_q <= '0;
            evade_q <= 1'b0;
            upd_q   <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (req) begin
                    win_q   <= win_d;
                    evade_q <= 1'b0;
                    upd_q   <= 1'b0;
                    phase   <= PH_WAIT;
                end
                PH_WAIT: begin
                    if (win_q.bypass) begin
                        start_q <= '0;
                        phase   <= PH_HELD;
                    end else if (outside) begin
                        start_q <= frame_cnt;
                        phase   <= PH_HELD;
                    end else if (expire) begin
                        start_q <= frame_cnt;
                        evade_q <= 1'b1;
                        phase   <= PH_HELD;
                    end
                end
                PH_HELD: if (done) begin
                    upd_q <= (start_q != '0) && (start_q != frame_cnt);
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign grant       = (phase == PH_HELD);
    assign start_count = start_q;
    assign evade_fail  = evade_q;
    assign update_fail = upd_q;
endmodule

// File: rtl/vbl_guard_chk.sv
module vbl_guard_chk #(
    parameter int FC_W        = 32,
    parameter int TIMEOUT_CYC = 250000
) (
    input logic            clk,
    input logic            rst,
    input logic            req,
    input logic            done,
    input logic            grant,
    input logic [FC_W-1:0] start_count,
    input logic            evade_fail,
    input logic            update_fail,
    input logic            in_wait
);
    localparam int CW = $clog2(TIMEOUT_CYC + 2);
    logic [CW-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst || !in_wait) wcnt <= '0;
        else                 wcnt <= wcnt + CW'(1);
    end

    AST_GRANT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        grant && !done |=> grant); // R7
    AST_START_STABLE: assert property (@(posedge clk) disable iff (rst)
        grant && !done |=> $stable(start_count)); // R7
    AST_GRANT_DROPS: assert property (@(posedge clk) disable iff (rst)
        grant && done |=> !grant); // R8
    AST_EVADE_WITH_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(evade_fail) |-> $rose(grant)); // R6
    AST_UPDFAIL_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(update_fail) |-> $past(grant && done)); // R8
    AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        req && !grant && !in_wait |=> !evade_fail && !update_fail); // R9
    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        in_wait |-> wcnt < CW'(TIMEOUT_CYC)); // R6
endmodule

bind vbl_guard vbl_guard_chk #(.FC_W(FC_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk(clk), .rst(rst), .req(req), .done(done), .grant(grant),
    .start_count(start_count), .evade_fail(evade_fail),
    .update_fail(update_fail), .in_wait(in_wait)
);

// File: tb/sim_vbl_guard.sv
`timescale 1ns/1ps
module sim_vbl_guard;
    localparam int TO = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] pix_khz = '0;
    logic [13:0] htotal = '0, vbl_start = '0, scanline = '0;
    logic        interlace = 1'b0;
    logic [31:0] frame_cnt = '0;
    logic        req = 1'b0, done = 1'b0;
    logic        grant, evade_fail, update_fail;
    logic [31:0] start_count;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    vbl_guard #(.TIMEOUT_CYC(TO)) u0 (
        .clk(clk), .rst(rst), .pix_khz(pix_khz), .htotal(htotal),
        .vbl_start(vbl_start), .interlace(interlace), .scanline(scanline),
        .frame_cnt(frame_cnt), .req(req), .done(done), .grant(grant),
        .start_count(start_count), .evade_fail(evade_fail),
        .update_fail(update_fail)
    );

    typedef struct packed {
        logic [19:0] pk;
        logic [13:0] ht;
        logic [13:0] vbl;
        logic        il;
        logic [13:0] line;
        logic        to;
        logic        byp;
        logic [3:0]  kind;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{20'd148500, 14'd2200, 14'd1080, 1'b0, 14'd1072, 1'b0, 1'b0, 4'd4},
        '{20'd148500, 14'd2200, 14'd1080, 1'b0, 14'd1073, 1'b1, 1'b0, 4'd4},
        '{20'd148500, 14'd2200, 14'd1080, 1'b0, 14'd1079, 1'b1, 1'b0, 4'd4},
        '{20'd148500, 14'd2200, 14'd1080, 1'b0, 14'd1080, 1'b0, 1'b0, 4'd4},
        '{20'd74250,  14'd2200, 14'd1081, 1'b1, 14'd536,  1'b0, 1'b0, 4'd3},
        '{20'd74250,  14'd2200, 14'd1081, 1'b1, 14'd537,  1'b1, 1'b0, 4'd3},
        '{20'd74250,  14'd2200, 14'd1081, 1'b1, 14'd540,  1'b1, 1'b0, 4'd3},
        '{20'd74250,  14'd2200, 14'd1081, 1'b1, 14'd541,  1'b0, 1'b0, 4'd3},
        '{20'd74250,  14'd2200, 14'd1081, 1'b0, 14'd540,  1'b0, 1'b0, 4'd3},
        '{20'd100000, 14'd0,    14'd500,  1'b0, 14'd499,  1'b1, 1'b0, 4'd2},
        '{20'd100000, 14'd0,    14'd500,  1'b0, 14'd498,  1'b0, 1'b0, 4'd2},
        '{20'd100000, 14'd1000, 14'd100,  1'b0, 14'd90,   1'b1, 1'b0, 4'd1},
        '{20'd100000, 14'd1000, 14'd100,  1'b0, 14'd89,   1'b0, 1'b0, 4'd1},
        '{20'd100001, 14'd1000, 14'd100,  1'b0, 14'd89,   1'b1, 1'b0, 4'd1},
        '{20'd148500, 14'd2200, 14'd5,    1'b0, 14'd3,    1'b0, 1'b1, 4'd5},
        '{20'd148500, 14'd2200, 14'd1,    1'b0, 14'd0,    1'b0, 1'b1, 4'd5},
        '{20'd148500, 14'd2200, 14'd0,    1'b0, 14'd0,    1'b0, 1'b1, 4'd5},
        '{20'd148500, 14'd2200, 14'd7,    1'b0, 14'd3,    1'b0, 1'b1, 4'd5},
        '{20'd148500, 14'd2200, 14'd8,    1'b0, 14'd3,    1'b1, 1'b0, 4'd5},
        '{20'd148500, 14'd2200, 14'd8,    1'b0, 14'd9,    1'b0, 1'b0, 4'd5}
    };

    function automatic string kname(input logic [3:0] k);
        case (k)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd5: return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic set_mode(input logic [19:0] pk, input logic [13:0] ht,
                            input logic [13:0] vb, input logic il,
                            input logic [13:0] ln);
        pix_khz = pk; htotal = ht; vbl_start = vb; interlace = il; scanline = ln;
    endtask

    // issue a request and return the cycles from capture edge to grant
    task automatic do_req(input int chg_at, input logic [13:0] chg_line,
                          input logic [13:0] chg_vbl, input logic [13:0] chg_ht,
                          output int lat);
        @(negedge clk);
        req = 1'b1;
        @(posedge clk);
        #1 req = 1'b0;
        lat = 0;
        forever begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == chg_at) begin
                scanline = chg_line; vbl_start = chg_vbl; htotal = chg_ht;
            end
            if (grant || lat > 1000) break;
        end
    endtask

    task automatic do_done();
        @(negedge clk);
        done = 1'b1;
        @(posedge clk);
        #1 done = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int lat;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12", "grant", grant, 0);
        chk("R12", "evade_fail", evade_fail, 0);
        chk("R12", "update_fail", update_fail, 0);
        chk("R12", "start_count", start_count, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v = VEC[i];
            set_mode(v.pk, v.ht, v.vbl, v.il, v.line);
            frame_cnt = 32'(200 + i);
            do_req(-1, 14'd0, 14'd0, 14'd0, lat);
            chk(kname(v.kind), "latency", lat, v.to ? TO : 1);
            chk(v.to ? "R6" : kname(v.kind), "evade_fail", evade_fail, v.to);
            chk(v.byp ? "R5" : "R7", "start_count", start_count,
                v.byp ? 0 : 200 + i);
            do_done();
            chk("R8", "grant after done", grant, 0);
            chk("R8", "update_fail same frame", update_fail, 0);
        end

        // R8 crossing detection, with R7 hold and stable start count
        set_mode(20'd148500, 14'd2200, 14'd1080, 1'b0, 14'd100);
        frame_cnt = 32'd50;
        do_req(-1, 14'd0, 14'd0, 14'd0, lat);
        chk("R4", "latency", lat, 1);
        frame_cnt = 32'd51;
        repeat (3) @(negedge clk);
        chk("R7", "grant held", grant, 1);
        chk("R7", "start_count held", start_count, 50);
        do_done();
        chk("R8", "update_fail crossed", update_fail, 1);

        // R9 next request clears update_fail
        do_req(-1, 14'd0, 14'd0, 14'd0, lat);
        chk("R9", "update_fail cleared", update_fail, 0);
        do_done();

        // R8 start count zero: no check
        frame_cnt = 32'd0;
        do_req(-1, 14'd0, 14'd0, 14'd0, lat);
        chk("R8", "start_count zero", start_count, 0);
        frame_cnt = 32'd1;
        do_done();
        chk("R8", "update_fail zero start", update_fail, 0);

        // R5 bypass with frame change: no check
        set_mode(20'd148500, 14'd2200, 14'd5, 1'b0, 14'd3);
        frame_cnt = 32'd77;
        do_req(-1, 14'd0, 14'd0, 14'd0, lat);
        frame_cnt = 32'd78;
        do_done();
        chk("R5", "update_fail bypass", update_fail, 0);

        // R10 timing change during wait is ignored
        set_mode(20'd148500, 14'd2200, 14'd1080, 1'b0, 14'd1073);
        frame_cnt = 32'd300;
        do_req(1, 14'd1073, 14'd2000, 14'd0, lat);
        chk("R10", "latency", lat, TO);
        chk("R10", "evade_fail", evade_fail, 1);
        do_done();

        // R9 next request clears evade_fail; R11 scanline leaves mid-wait
        set_mode(20'd148500, 14'd2200, 14'd1080, 1'b0, 14'd1075);
        do_req(5, 14'd1080, 14'd1080, 14'd2200, lat);
        chk("R11", "latency", lat, 6);
        chk("R9", "evade_fail cleared", evade_fail, 0);
        chk("R11", "start_count", start_count, 300);
        do_done();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule